// File: doc/BRIEF.md
# Interrupt Distributor Configuration Register File

This block is the storage side of an interrupt distributor. It keeps one priority byte and one CPU-target byte per interrupt, and it offers two read-only words that describe the configuration. Software reaches these through a simple request port that takes aligned 32-bit word accesses or single-byte accesses. The block only stores configuration and returns it. It does no signalling, arbitration or CPU-side handling.

The block masks what hardware does not implement. Priority bytes keep only their upper `PRIO_BITS` bits. Target bytes keep only one bit per existing CPU. Locations past the last implemented interrupt read as zero and drop writes. The target bytes of the 32 private interrupts (0 to 31) cannot be written. Each of them reports the bit of the CPU that performs the access.

Address map, byte addresses on a 12-bit port:
- 0x000: configuration word.
- 0x004: identification word.
- 0x400 to 0x7FF: priority bytes, one per interrupt, interrupt n at 0x400+n.
- 0x800 to 0xBFF: target bytes, interrupt n at 0x800+n.

Top module: `irqd_cfg_regs`

## Requirements
- R1: A read of 0x000 returns bits [4:0] = NUM_IRQ/32 − 1, bits [7:5] = NUM_CPU − 1, and zero in all other bits.
- R2: The words at 0x000 and 0x004 are read-only, and 0x004 always returns ID_VALUE. Writing all ones, 0xA5A55A5A or zero leaves both words unchanged.
- R3: Every interrupt 0..NUM_IRQ−1 has a writable priority byte. Only its top PRIO_BITS bits are stored, and its low 8−PRIO_BITS bits read as zero. Writing all ones to a word therefore reads back as the same mask in all four bytes.
- R4: Priority bytes at offsets NUM_IRQ and above, within the priority window, read as zero and ignore writes. The last implemented word (the 4 interrupts just below NUM_IRQ) is fully writable.
- R5: In the target byte of a shared interrupt, bit k holds CPU k for k < NUM_CPU. Bits for CPU numbers NUM_CPU and above read as zero and ignore writes.
- R6: Target bytes at offsets NUM_IRQ and above, within the target window, read as zero and ignore writes.
- R7: The target bytes of interrupts 0..31 ignore writes. A read of one returns a one-hot byte with bit cpu_id set, or zero when cpu_id ≥ NUM_CPU.
- R8: A read with byte_acc=1 returns the byte at the addressed location in rdata[7:0], with rdata[31:8] zero.
- R9: A write with byte_acc=1 takes its data from wdata[7:0] and changes only the addressed byte.
- R10: A word access (byte_acc=0) ignores addr[1:0] and covers 4 interrupts at once. Interrupt 4w+k maps to bits [8k+7:8k] of word w.
- R11: rvalid is high exactly in the cycle after a read request and carries that read's data. A write is visible to a read issued in the next cycle. A write request produces no rvalid.
- R12: After reset, every priority byte and every shared target byte reads as zero.
- R13: Addresses 0x008 to 0x3FF and 0xC00 to 0xFFF read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| byte_acc | input | 1 | 1 = single-byte access, 0 = aligned word access |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| cpu_id | input | 3 | Number of the CPU making the access |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Read data |

## Verification
Assertions check the following on every cycle:
- The read-response timing.
- The fixed contents of the configuration and identification words.
- Zero in the unimplemented priority bits and in the target bits of absent CPUs.
- Zero returned past the implemented interrupt range.
- The one-hot value returned for a private target byte.

Some properties only the bench's scenarios can show:
- Writes are ignored where they must be.
- A byte write leaves the neighbouring bytes alone.
- The last word below the interrupt limit stays fully writable.
- Reset clears the stored values.

The bench shows these by writing patterns and reading them back, compared against a behavioural model on every clock.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int CPU_IDW = 3;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_INFO,
        RGN_PRIO,
        RGN_TGT
    } region_e;

    typedef struct packed {
        region_e    rgn;
        logic       info_sel;   // 0: configuration word, 1: identification word
        logic [7:0] widx;       // word index inside a 1 KiB window
        logic [1:0] lane;       // byte lane inside the word
    } dec_t;

    typedef struct packed {
        logic              en;
        logic [3:0]        be;
        logic [DATA_W-1:0] data;
    } wr_t;

    // Configuration word: interrupt blocks of 32 minus one, CPU count minus one.
    function automatic logic [DATA_W-1:0] cfg_word(int nirq, int ncpu);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[4:0] = 5'(nirq / 32 - 1);
        w[7:5] = 3'(ncpu - 1);
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] lane_pick(logic [DATA_W-1:0] w, logic [1:0] l);
        return (w >> {l, 3'b000}) & 32'h0000_00FF;
    endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.widx     = addr[9:2];
        dec.lane     = addr[1:0];
        dec.info_sel = addr[2];
        dec.rgn      = RGN_NONE;
        unique case (addr[11:10])
            2'b00:   if (addr[9:3] == 7'd0) dec.rgn = RGN_INFO;
            2'b01:   dec.rgn = RGN_PRIO;
            2'b10:   dec.rgn = RGN_TGT;
            default: dec.rgn = RGN_NONE;
        endcase
    end

endmodule

// File: rtl/irqd_prio_bank.sv
module irqd_prio_bank
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        widx,
    input  logic [3:0]        be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    localparam int NUM_WORDS = NUM_IRQ / 4;
    localparam int LOW_BITS  = 8 - PRIO_BITS;

    logic [NUM_IRQ*8-1:0] flat;
    logic                 unused_wbits;

    assign unused_wbits = ^wdata;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic [PRIO_BITS-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && widx == 8'(i / 4) && be[i % 4])
                q <= wdata[(i % 4) * 8 + LOW_BITS +: PRIO_BITS];
        end
        assign flat[i*8 +: 8] = 8'(q) << LOW_BITS;
    end

    always_comb begin
        if (int'(widx) < NUM_WORDS)
            rword = flat[int'(widx) * 32 +: 32];
        else
            rword = '0;
    end

endmodule

// File: rtl/irqd_tgt_bank.sv
module irqd_tgt_bank
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [7:0]         widx,
    input  logic [3:0]         be,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CPU_IDW-1:0] cpu_id,
    output logic [DATA_W-1:0]  rword
);

    localparam int NUM_WORDS = NUM_IRQ / 4;
    localparam int NUM_PRIV  = 32;

    logic [NUM_IRQ*8-1:0] flat;
    logic [7:0]           own;
    logic                 unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb own = (int'(cpu_id) < NUM_CPU) ? (8'd1 << cpu_id) : 8'd0;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        if (i < NUM_PRIV) begin : g_priv
            assign flat[i*8 +: 8] = own;
        end else begin : g_shared
            logic [NUM_CPU-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_en && widx == 8'(i / 4) && be[i % 4])
                    q <= wdata[(i % 4) * 8 +: NUM_CPU];
            end
            assign flat[i*8 +: 8] = 8'(q);
        end
    end

    always_comb begin
        if (int'(widx) < NUM_WORDS)
            rword = flat[int'(widx) * 32 +: 32];
        else
            rword = '0;
    end

endmodule

// File: rtl/irqd_cfg_regs.sv
module irqd_cfg_regs
    import irqd_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,   // multiple of 32, 32..1024
    parameter int          NUM_CPU   = 4,    // 1..8
    parameter int          PRIO_BITS = 5,    // 4..8
    parameter logic [31:0] ID_VALUE  = 32'h0043_B0A1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic               byte_acc,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CPU_IDW-1:0] cpu_id,
    output logic               rvalid,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [DATA_W-1:0] CFG_VALUE = cfg_word(NUM_IRQ, NUM_CPU);
    localparam logic [7:0]        PRIO_BYTE = 8'(255 << (8 - PRIO_BITS));
    localparam logic [7:0]        TGT_BYTE  = 8'((1 << NUM_CPU) - 1);
    localparam logic [DATA_W-1:0] PRIO_KEEP = {4{PRIO_BYTE}};
    localparam logic [DATA_W-1:0] TGT_KEEP  = {4{TGT_BYTE}};

    dec_t              dec;
    wr_t               wr;
    logic [DATA_W-1:0] prio_word;
    logic [DATA_W-1:0] tgt_word;
    logic [DATA_W-1:0] word;

    irqd_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    always_comb begin
        wr.en   = req && we;
        wr.be   = byte_acc ? (4'd1 << dec.lane) : 4'hF;
        wr.data = byte_acc ? {4{wdata[7:0]}} : wdata;
    end

    irqd_prio_bank #(
        .NUM_IRQ   (NUM_IRQ),
        .PRIO_BITS (PRIO_BITS)
    ) u_prio (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr.en && dec.rgn == RGN_PRIO),
        .widx  (dec.widx),
        .be    (wr.be),
        .wdata (wr.data),
        .rword (prio_word)
    );

    irqd_tgt_bank #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_CPU (NUM_CPU)
    ) u_tgt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr.en && dec.rgn == RGN_TGT),
        .widx   (dec.widx),
        .be     (wr.be),
        .wdata  (wr.data),
        .cpu_id (cpu_id),
        .rword  (tgt_word)
    );

    always_comb begin
        unique case (dec.rgn)
            RGN_INFO: word = dec.info_sel ? ID_VALUE : CFG_VALUE;
            RGN_PRIO: word = prio_word;
            RGN_TGT:  word = tgt_word;
            default:  word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= req && !we;
            if (req && !we)
                rdata <= byte_acc ? lane_pick(word, dec.lane) : word;
        end
    end

    // R11
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid == $past(req && !we));

    // R1
    cfg_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && !byte_acc && addr == 12'h000) |-> rdata == CFG_VALUE);

    // R2
    ident_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && !byte_acc && addr == 12'h004) |-> rdata == ID_VALUE);

    // R3
    prio_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && addr[11:10] == 2'b01) |-> (rdata & ~PRIO_KEEP) == '0);

    // R4
    prio_beyond_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && addr[11:10] == 2'b01 && int'(addr[9:0]) >= NUM_IRQ) |-> rdata == '0);

    // R5
    tgt_cpu_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && addr[11:10] == 2'b10) |-> (rdata & ~TGT_KEEP) == '0);

    // R7
    tgt_private_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req && !we && byte_acc && addr[11:10] == 2'b10 && addr[9:5] == 5'd0) |->
        rdata == ((int'($past(cpu_id)) < NUM_CPU) ? (32'd1 << $past(cpu_id)) : 32'd0));

endmodule

// File: tb/irqd_cfg_regs_test.sv
module irqd_cfg_regs_test;

    localparam int          NI  = 64;
    localparam int          NC  = 4;
    localparam int          PB  = 5;
    localparam logic [31:0] IDV = 32'h0043_B0A1;
    localparam int          PMASK = (255 << (8 - PB)) & 255;
    localparam int          CMASK = (1 << NC) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic        byte_acc = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  cpu_id = '0;
    logic        rvalid;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    irqd_cfg_regs #(
        .NUM_IRQ   (NI),
        .NUM_CPU   (NC),
        .PRIO_BITS (PB),
        .ID_VALUE  (IDV)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .we       (we),
        .byte_acc (byte_acc),
        .addr     (addr),
        .wdata    (wdata),
        .cpu_id   (cpu_id),
        .rvalid   (rvalid),
        .rdata    (rdata)
    );

    // ---------------- behavioural reference model ----------------
    int          p_m [1024];
    int          t_m [1024];
    bit          exp_rv = 0;
    logic [31:0] exp_rd = '0;

    function automatic int tbyte(int off, int cpu);
        if (off < 32) return (cpu < NC) ? (1 << cpu) : 0;
        if (off < NI) return t_m[off];
        return 0;
    endfunction

    function automatic logic [31:0] mread(logic [11:0] a, bit b, int cpu);
        logic [31:0] w;
        int base;
        w = '0;
        base = int'(a) & 'hFFC;
        if (base == 0)
            w = 32'(((NC - 1) << 5) | (NI / 32 - 1));
        else if (base == 4)
            w = IDV;
        else if (base >= 'h400 && base < 'h800) begin
            for (int k = 0; k < 4; k++)
                w[8*k +: 8] = 8'((base - 'h400 + k < NI) ? p_m[base - 'h400 + k] : 0);
        end else if (base >= 'h800 && base < 'hC00) begin
            for (int k = 0; k < 4; k++)
                w[8*k +: 8] = 8'(tbyte(base - 'h800 + k, cpu));
        end
        if (b) w = (w >> (8 * (int'(a) % 4))) & 32'hFF;
        return w;
    endfunction

    function automatic void mwrite(logic [11:0] a, bit b, logic [31:0] d);
        int base;
        int v;
        int off;
        base = int'(a) & 'hFFC;
        for (int k = 0; k < 4; k++) begin
            if (!b || k == int'(a) % 4) begin
                v = b ? int'(d[7:0]) : int'(d[8*k +: 8]);
                if (base >= 'h400 && base < 'h800) begin
                    off = base - 'h400 + k;
                    if (off < NI) p_m[off] = v & PMASK;
                end else if (base >= 'h800 && base < 'hC00) begin
                    off = base - 'h800 + k;
                    if (off >= 32 && off < NI) t_m[off] = v & CMASK;
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) begin
                p_m[i] = 0;
                t_m[i] = 0;
            end
            exp_rv = 0;
        end else begin
            exp_rv = req && !we;
            if (req && !we) exp_rd = mread(addr, byte_acc, int'(cpu_id));
            if (req && we) mwrite(addr, byte_acc, wdata);
        end
    end

    // Every-clock comparison against the model (R11 timing and all data).
    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (rvalid !== exp_rv || (exp_rv && rdata !== exp_rd)) begin
                bad++;
                $display("FAIL R11 model compare: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         rvalid, rdata, exp_rv, exp_rd);
            end
        end
    end

    // ---------------- directed access tasks ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input bit b, input logic [31:0] d, input int cpu);
        @(negedge clk);
        req = 1; we = 1; byte_acc = b; addr = a; wdata = d; cpu_id = 3'(cpu);
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic do_rd(input logic [11:0] a, input bit b, input int cpu,
                         input logic [31:0] exp, input string tag);
        @(negedge clk);
        req = 1; we = 0; byte_acc = b; addr = a; cpu_id = 3'(cpu);
        @(negedge clk);
        req = 0;
        chk(tag, rvalid ? rdata : 32'hDEAD_BEEF, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R12 reset state
        do_rd(12'h420, 0, 0, 32'h0, "R12 prio after reset");
        do_rd(12'h820, 0, 0, 32'h0, "R12 target after reset");

        // R1 / R2
        do_rd(12'h000, 0, 0, 32'h0000_0061, "R1 configuration word");
        do_rd(12'h004, 0, 0, IDV, "R2 identification word");
        do_wr(12'h000, 0, 32'hFFFF_FFFF, 0);
        do_wr(12'h004, 0, 32'hA5A5_5A5A, 0);
        do_rd(12'h000, 0, 0, 32'h0000_0061, "R2 configuration unchanged");
        do_rd(12'h004, 0, 0, IDV, "R2 identification unchanged");
        do_wr(12'h000, 0, 32'h0, 0);
        do_wr(12'h004, 0, 32'h0, 0);
        do_rd(12'h000, 0, 0, 32'h0000_0061, "R2 configuration after zero write");
        do_rd(12'h004, 0, 0, IDV, "R2 identification after zero write");

        // R3 priority masking
        do_wr(12'h420, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'h420, 0, 0, 32'hF8F8_F8F8, "R3 all-ones priority mask");
        do_wr(12'h400, 0, 32'hA5A5_5A5A, 0);
        do_rd(12'h400, 0, 0, 32'hA0A0_5858, "R3 private priority stored");
        do_wr(12'h420, 0, 32'hFF7F_BF3F, 0);
        do_rd(12'h420, 0, 0, 32'hF878_B838, "R10 lanes preserved");

        // R8 / R9 byte access on priorities
        do_rd(12'h421, 1, 0, 32'h0000_00B8, "R8 priority byte read");
        do_wr(12'h422, 1, 32'hFFFF_FF1F, 0);
        do_rd(12'h420, 0, 0, 32'hF818_B838, "R9 priority byte write");

        // R4 range boundary
        do_wr(12'h43C, 0, 32'h1234_5678, 0);
        do_rd(12'h43C, 0, 0, 32'h1030_5078, "R4 last word writable");
        do_wr(12'h440, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'h440, 0, 0, 32'h0, "R4 priority beyond limit");
        do_rd(12'h7FC, 0, 0, 32'h0, "R4 priority window end");

        // R5 target masking
        do_wr(12'h820, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'h820, 0, 0, 32'h0F0F_0F0F, "R5 absent CPU bits");
        do_wr(12'h820, 0, 32'h8040_2010, 0);
        do_rd(12'h820, 0, 0, 32'h0, "R5 high bits only");
        do_wr(12'h820, 0, 32'h0103_020F, 0);
        do_rd(12'h820, 0, 0, 32'h0103_020F, "R5 target preserved");
        do_rd(12'h821, 1, 0, 32'h0000_0002, "R8 target byte read");
        do_wr(12'h822, 1, 32'h0000_001F, 0);
        do_rd(12'h820, 0, 0, 32'h010F_020F, "R9 target byte write");
        do_rd(12'h822, 0, 0, 32'h010F_020F, "R10 word ignores low address bits");

        // R6
        do_wr(12'h840, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'h840, 0, 0, 32'h0, "R6 target beyond limit");
        do_rd(12'hBFC, 0, 0, 32'h0, "R6 target window end");

        // R7 private targets
        do_rd(12'h800, 0, 2, 32'h0404_0404, "R7 own bit cpu2");
        do_wr(12'h800, 0, 32'hFFFF_FFFF, 2);
        do_rd(12'h800, 0, 2, 32'h0404_0404, "R7 write ignored");
        do_rd(12'h800, 0, 0, 32'h0101_0101, "R7 own bit cpu0");
        do_rd(12'h81F, 1, 3, 32'h0000_0008, "R7 byte read cpu3");
        do_rd(12'h804, 0, 5, 32'h0, "R7 absent cpu reads zero");

        // R13 unmapped
        do_wr(12'h100, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'h100, 0, 0, 32'h0, "R13 unmapped low");
        do_wr(12'hC00, 0, 32'hFFFF_FFFF, 0);
        do_rd(12'hC00, 0, 0, 32'h0, "R13 unmapped high");

        // R11 write gives no rvalid
        @(negedge clk);
        req = 1; we = 1; byte_acc = 0; addr = 12'h430; wdata = 32'h5555_5555;
        @(negedge clk);
        req = 0; we = 0;
        chk("R11 no rvalid on write", 32'(rvalid), 32'h0);
        do_rd(12'h430, 0, 0, 32'h5050_5050, "R11 write visible next read");

        // R12 reset again
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        do_rd(12'h420, 0, 0, 32'h0, "R12 prio cleared by reset");
        do_rd(12'h820, 0, 0, 32'h0, "R12 target cleared by reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule